// File: doc/BRIEF.md
# Control Register Port Write Sequencer

This block performs one write into a PHY's internal control-register space. That space is reached through a narrow port made of a command word and a status word. A single request carries a 16-bit register address and a 16-bit value. The block turns that request into three strobe/acknowledge exchanges in a fixed order: it captures the address, then captures the data, then commits the write. Each exchange is a full four-phase cycle. The strobe is raised and held until the acknowledge rises. The strobe is then dropped, and the block waits for the acknowledge to fall.

The wait for each acknowledge edge is bounded by a timer. A prescaler turns the clock into microsecond ticks, and a counter counts the ticks up to a wait limit. When a wait expires, the block flags an error and carries on as if the edge had arrived, so the sequence always runs to its end. The acknowledge is taken through a two-flop synchronizer because the PHY logic may run on another clock. A request is taken only while the block is idle, and the address and data are latched at that moment.

Top module: `crport_write_master`

## Requirements
- R1: After reset the command word is all zeros, and busy, done and error are all low.
- R2: The command word layout is: capture-address strobe at bit 0, capture-data strobe at bit 1, data-in at bits [17:2], read strobe at bit 18, write strobe at bit 19. The status word carries the acknowledge at bit 0. Data-in carries the address latched at acceptance during the address exchange, and the data latched at acceptance during the other two exchanges.
- R3: Each write raises exactly three strobes in the order capture-address, capture-data, write, and never more than one strobe at a time.
- R4: A strobe stays high until the synchronized acknowledge is high or its wait expires. The next strobe is not raised until the acknowledge has been seen low or that wait expires.
- R5: Every strobe is preceded by at least one cycle in which its data-in value is already driven with all strobes low.
- R6: If the acknowledge never rises, each wait for the rise ends after CLK_PER_US×WAIT_US cycles. The error flag is then set, and all three strobes are still issued.
- R7: If the acknowledge never falls, each wait for the fall ends after CLK_PER_US×WAIT_US cycles. The error flag is then set, and the sequence still completes.
- R8: The error flag stays set after the write ends, and it is cleared when the next request is accepted.
- R9: Done is high for exactly one cycle, in the first cycle after the final acknowledge-low (or its timeout). Busy is high from the cycle after acceptance through the last cycle of the final exchange.
- R10: A request raised while busy is ignored. It causes no extra write, and a change of address or data inputs after acceptance has no effect on the write in progress.
- R11: The read strobe (bit 18) is never raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a write (sampled while idle) |
| addr_i | input | DW | Control-register address |
| data_i | input | DW | Value to write |
| stat_i | input | DW+1 | Status word from the PHY port (bit 0 acknowledge) |
| cmd_o | output | DW+4 | Command word to the PHY port |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky wait-timeout flag |

## Verification
The bench builds the block with CLK_PER_US=4 and WAIT_US=5, so each bounded wait lasts 20 cycles instead of 20,000. At that size the bench can count exact busy durations for both timeout directions (66 cycles per write) alongside normal writes. A responder model acknowledges after a short delay, stays silent, or holds the acknowledge high. Through it the bench checks the captured address and data, the strobe order, the setup cycle before each strobe, and that no strobe drops early.

// File: rtl/crport_write_master.sv
module crport_write_master #(
  parameter int DW         = 16,
  parameter int CLK_PER_US = 200,
  parameter int WAIT_US    = 100
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW:0]   stat_i,
  output logic [DW+3:0] cmd_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);

  localparam int PW = $clog2(CLK_PER_US + 1);
  localparam int WW = $clog2(WAIT_US + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RAISE, S_DROP} state_t;

  state_t        state;
  logic [1:0]    phase;
  logic [DW-1:0] addr_q, data_q;
  logic          ack_m, ack_s;
  logic [PW-1:0] presc;
  logic [WW-1:0] wcnt;
  logic          err_q, done_q;

  logic tick, timeout, raise_ok, drop_ok, moving, last_phase;
  logic [DW-1:0] din;
  logic cap_a, cap_d, wr;

  assign tick       = (presc == PW'(CLK_PER_US - 1));
  assign timeout    = tick && (wcnt == WW'(WAIT_US - 1));
  assign raise_ok   = ack_s || timeout;
  assign drop_ok    = !ack_s || timeout;
  assign last_phase = (phase == 2'd2);
  assign moving     = (state == S_SETUP) ||
                      (state == S_RAISE && raise_ok) ||
                      (state == S_DROP  && drop_ok) ||
                      (state == S_IDLE  && req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= stat_i[0];
      ack_s <= ack_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      wcnt  <= '0;
    end else if (moving) begin
      presc <= '0;
      wcnt  <= '0;
    end else if (tick) begin
      presc <= '0;
      wcnt  <= wcnt + 1'b1;
    end else begin
      presc <= presc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      phase  <= 2'd0;
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (req_i) begin
          addr_q <= addr_i;
          data_q <= data_i;
          phase  <= 2'd0;
          err_q  <= 1'b0;
          state  <= S_SETUP;
        end
        S_SETUP: state <= S_RAISE;
        S_RAISE: if (raise_ok) begin
          if (!ack_s) err_q <= 1'b1;
          state <= S_DROP;
        end
        S_DROP: if (drop_ok) begin
          if (ack_s) err_q <= 1'b1;
          if (last_phase) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            phase <= phase + 1'b1;
            state <= S_SETUP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign din   = (state == S_IDLE) ? '0 : ((phase == 2'd0) ? addr_q : data_q);
  assign cap_a = (state == S_RAISE) && (phase == 2'd0);
  assign cap_d = (state == S_RAISE) && (phase == 2'd1);
  assign wr    = (state == S_RAISE) && (phase == 2'd2);
  assign cmd_o  = {wr, 1'b0, din, cap_d, cap_a};
  assign busy_o = (state != S_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_o[DW+3], cmd_o[1], cmd_o[0]}));

  // R3
  strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_o[DW+3]) |-> !busy_o || phase == 2'd2);

  // R4
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RAISE && !ack_s && !timeout) |=> state == S_RAISE);

  // R5
  setup_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|{cmd_o[DW+3], cmd_o[1:0]}) |->
      $past({cmd_o[DW+3], cmd_o[1:0]}) == 3'b000 && $past(cmd_o[DW+1:2]) == cmd_o[DW+1:2]);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o));

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !err_o);

  // R10
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_i));

endmodule

// File: tb/crport_write_master_tb.sv
`timescale 1ns/1ps
module crport_write_master_tb_top;
  localparam int DW = 16;
  localparam int TD = 4;
  localparam int WT = 5;
  localparam int WR_CYC = 3 * (2 + TD * WT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0;
  logic [DW-1:0] addr_i = '0, data_i = '0;
  logic ack = 1'b0;
  logic [DW:0] stat_i;
  logic [DW+3:0] cmd_o;
  logic busy_o, done_o, err_o;

  int checks = 0, fails = 0;

  assign stat_i = {{DW{1'b0}}, ack};
  always #2.5 clk = ~clk;

  crport_write_master #(.DW(DW), .CLK_PER_US(TD), .WAIT_US(WT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .data_i(data_i),
    .stat_i(stat_i), .cmd_o(cmd_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  // responder: 0 normal, 1 silent, 2 ack stuck high
  int mode = 0;
  int dcnt = 0;
  int seq = 0, wr_cnt = 0, setup_err = 0, early_drop = 0, read_seen = 0;
  logic [DW-1:0] cap_addr = '0, wr_addr = '0, wr_data = '0;
  logic prev_strb = 1'b0;
  logic [DW-1:0] prev_din = '0;

  always @(negedge clk) begin
    logic strb;
    strb = cmd_o[0] | cmd_o[1] | cmd_o[19];
    if (cmd_o[18]) read_seen++;
    if (strb && !prev_strb) begin
      if (prev_din != cmd_o[17:2]) setup_err++;
      if (cmd_o[0]) begin seq = seq * 4 + 1; cap_addr = cmd_o[17:2]; end
      if (cmd_o[1]) seq = seq * 4 + 2;
      if (cmd_o[19]) begin seq = seq * 4 + 3; wr_cnt++; wr_addr = cap_addr; wr_data = cmd_o[17:2]; end
    end
    if (!strb && prev_strb && mode == 0 && !ack) early_drop++;
    prev_strb = strb;
    prev_din  = cmd_o[17:2];
    if (mode == 1) ack <= 1'b0;
    else if (mode == 2) ack <= 1'b1;
    else if (strb != ack) begin
      dcnt++;
      if (dcnt >= 2) begin ack <= strb; dcnt = 0; end
    end else dcnt = 0;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns busy cycle count; checks done pulse
  task automatic run_write(input logic [DW-1:0] a, input logic [DW-1:0] d, output int n);
    @(negedge clk);
    addr_i = a; data_i = d; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0; addr_i = ~a; data_i = ~d;
    check(!err_o, "R8 err cleared at accept", err_o, 0);
    n = 0;
    while (busy_o && n < 2000) begin n++; @(negedge clk); end
    check(done_o, "R9 done after final exchange", done_o, 1);
    @(negedge clk);
    check(!done_o, "R9 done one cycle", done_o, 0);
  endtask

  task automatic t_reset;
    check(cmd_o == '0, "R1 cmd reset", cmd_o, 0);
    check(!busy_o && !done_o && !err_o, "R1 flags reset", {busy_o, done_o, err_o}, 0);
  endtask

  task automatic t_write(input logic [DW-1:0] a, input logic [DW-1:0] d);
    int n, w0;
    mode = 0; repeat (6) @(negedge clk);
    seq = 0; w0 = wr_cnt;
    run_write(a, d, n);
    check(wr_cnt == w0 + 1, "R3 one commit", wr_cnt - w0, 1);
    check(seq == 27, "R3 strobe order", seq, 27);
    check(wr_addr == a, "R2 address field", wr_addr, a);
    check(wr_data == d, "R2 data field", wr_data, d);
    check(setup_err == 0, "R5 setup cycle", setup_err, 0);
    check(early_drop == 0, "R4 strobe held for ack", early_drop, 0);
    check(!err_o, "R6 no error on normal write", err_o, 0);
    check(read_seen == 0, "R11 read strobe idle", read_seen, 0);
  endtask

  task automatic t_timeout_rise;
    int n;
    mode = 1; repeat (6) @(negedge clk);
    seq = 0;
    run_write(16'h0015, 16'hA409, n);
    check(n == WR_CYC, "R6 rise-wait duration", n, WR_CYC);
    check(err_o, "R6 error flagged", err_o, 1);
    check(seq == 27, "R6 sequence continues", seq, 27);
    repeat (5) @(negedge clk);
    check(err_o, "R8 error sticky", err_o, 1);
  endtask

  task automatic t_timeout_fall;
    int n;
    mode = 2; repeat (6) @(negedge clk);
    seq = 0;
    run_write(16'h0012, 16'hA000, n);
    check(n == WR_CYC, "R7 fall-wait duration", n, WR_CYC);
    check(err_o, "R7 error flagged", err_o, 1);
    check(seq == 27, "R7 sequence completes", seq, 27);
  endtask

  task automatic t_busy_ignore;
    int n, w0;
    mode = 0; repeat (6) @(negedge clk);
    w0 = wr_cnt;
    @(negedge clk);
    addr_i = 16'h1010; data_i = 16'h0080; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    repeat (3) @(negedge clk);
    addr_i = 16'h5555; data_i = 16'h6666; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    n = 0;
    while (busy_o && n < 2000) begin n++; @(negedge clk); end
    repeat (5) @(negedge clk);
    check(!busy_o, "R10 no restart", busy_o, 0);
    check(wr_cnt == w0 + 1, "R10 single write", wr_cnt - w0, 1);
    check(wr_addr == 16'h1010, "R10 address latched", wr_addr, 16'h1010);
    check(wr_data == 16'h0080, "R10 data latched", wr_data, 16'h0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(16'h0015, 16'hA409);
    t_write(16'hFFFF, 16'h0000);
    t_write(16'h0000, 16'hFFFF);
    t_timeout_rise();
    t_write(16'h1010, 16'h0040);
    t_timeout_fall();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule